// File: doc/BRIEF.md
# Performance Monitor Counter Bank

The block holds six 32-bit event counters for a processor core. Each clock cycle it receives three event inputs: a count of instructions completed in that cycle (0 to 7), a cycle tick, and a run-latch status bit. The first four counters each take an 8-bit event selector that chooses what they count. Counter 5 is fixed to completed instructions and counter 6 is fixed to cycles. A first control word holds three freeze bits, two overflow enables and an exception enable. A second control word holds the four selectors.

When a counter that has its overflow enable set reaches or passes the sign-bit value, it is pinned to exactly that value and an overflow is signalled. If exceptions are enabled, the overflow sets a sticky interrupt flag, which software clears with a register write. Software reaches every counter and control through a plain register port. Writes are synchronous and reads are combinational. The block carries no streaming data, so every pin is plain control or status with no valid/ready handshake.

Register addresses (4 bits):

| Address | Contents |
|---|---|
| 0 to 5 | Counters 1 to 6 |
| 6 | Control word 0 |
| 7 | Control word 1 |
| 8 | Interrupt flag |

Control word 0 bit layout:

| Bit | Function |
|---|---|
| 0 | Freeze all counters |
| 1 | Freeze counters 1 to 4 |
| 2 | Freeze counters 5 and 6 |
| 3 | Counter 1 overflow enable |
| 4 | Overflow enable shared by counters 2 to 6 |
| 5 | Exception enable |

In control word 1, counter 1's selector sits in bits [7:0], counter 2's in [15:8], counter 3's in [23:16] and counter 4's in [31:24]. Address 8 reads the flag in bit 0. Writing address 8 with bit 0 set clears the flag.

Top module: `perf_counter_bank`

## Requirements
- R1: After reset, every counter, both control words and the interrupt flag read as zero, and `irq` is low.
- R2: Control word 0 bit 0 stops all six counters. Bit 1 stops only counters 1 to 4. Bit 2 stops only counters 5 and 6.
- R3: Counter 5 adds `inst_done` on every unfrozen cycle. Counter 6 adds 1 on every unfrozen cycle in which `cyc_tick` is high. Neither counter has a selector.
- R4: On counters 1 to 4, selector 0x02 adds `inst_done` each cycle, and selector 0x1E adds 1 per cycle in which `cyc_tick` is high.
- R5: On counter 1, selector 0xF0 counts cycle ticks and selector 0xFE counts completed instructions. On counters 2 to 4 both of these codes count nothing.
- R6: Selector 0xFA counts `inst_done` only on counter 4, and only in cycles where `run_latch` is high. On counters 1 to 3 it counts nothing.
- R7: Any other selector value leaves its counter unchanged.
- R8: Counter 1 uses overflow enable bit 3, and counters 2 to 6 use bit 4. If an increment brings a counter whose enable is set to 0x80000000 or above, the counter becomes exactly 0x80000000. If the enable is clear, the counter wraps modulo 2^32.
- R9: An overflow in a cycle where control word 0 bit 5 is set raises `irq` at the same edge as the counter update. `irq` then stays high until a write to address 8 with bit 0 set. An overflow without bit 5 leaves `irq` low.
- R10: A write to a counter in a cycle where that counter also increments loads the written value. Counting resumes from that value in the next cycle.
- R11: A write to a control word takes effect from the cycle after the write. Increments in the write cycle use the old settings.
- R12: `reg_rd_data` shows the register at `reg_rd_addr` combinationally, and unmapped addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 4 | Write address |
| reg_wr_data | input | 32 | Write data |
| reg_rd_addr | input | 4 | Read address |
| reg_rd_data | output | 32 | Read data (combinational) |
| inst_done | input | 3 | Instructions completed this cycle |
| cyc_tick | input | 1 | Cycle event for this cycle |
| run_latch | input | 1 | Thread run-latch status |
| irq | output | 1 | Sticky overflow interrupt request |

## Verification
Every counter, control word and flag result is due exactly one rising edge after the cycle that carries its stimulus, and register reads show the new value with no further delay. The bench drives all inputs on the falling edge, lets one rising edge pass, and reads back through the read port a moment after the next falling edge. For the same-edge cases (a write racing an increment, a control change racing an event), it checks both the edge of the write and the edge after it, which proves which setting applied in each cycle.

// File: rtl/pcb_pkg.sv
package pcb_pkg;
  localparam int SEL_W   = 8;
  localparam int N_SEL   = 4;

  localparam logic [SEL_W-1:0] SEL_INST    = 8'h02;
  localparam logic [SEL_W-1:0] SEL_CYC     = 8'h1E;
  localparam logic [SEL_W-1:0] SEL_C1_CYC  = 8'hF0;
  localparam logic [SEL_W-1:0] SEL_C1_INST = 8'hFE;
  localparam logic [SEL_W-1:0] SEL_C4_RUN  = 8'hFA;

  typedef enum logic [1:0] {
    EV_NONE     = 2'd0,
    EV_INST     = 2'd1,
    EV_CYC      = 2'd2,
    EV_INST_RUN = 2'd3
  } ev_kind_e;

  typedef struct packed {
    logic exc_en;
    logic ovf_en_rest;
    logic ovf_en_c1;
    logic frz_hi;
    logic frz_lo;
    logic frz_all;
  } ctl0_t;

  localparam int CTL0_W = $bits(ctl0_t);
endpackage

// File: rtl/pcb_event_decode.sv
module pcb_event_decode
  import pcb_pkg::*;
#(
  parameter int IDX    = 0,
  parameter int INST_W = 3
) (
  input  logic [SEL_W-1:0]  sel,
  input  ctl0_t             ctl,
  input  logic [INST_W-1:0] inst_done,
  input  logic              cyc_tick,
  input  logic              run_latch,
  output logic              frozen,
  output logic [INST_W-1:0] inc
);
  ev_kind_e kind;

  generate
    if (IDX == 4) begin : g_fixed_inst
      assign kind = EV_INST;
    end else if (IDX == 5) begin : g_fixed_cyc
      assign kind = EV_CYC;
    end else begin : g_selected
      always_comb begin
        kind = EV_NONE;
        case (sel)
          SEL_INST:    kind = EV_INST;
          SEL_CYC:     kind = EV_CYC;
          SEL_C1_CYC:  kind = (IDX == 0) ? EV_CYC  : EV_NONE;
          SEL_C1_INST: kind = (IDX == 0) ? EV_INST : EV_NONE;
          SEL_C4_RUN:  kind = (IDX == 3) ? EV_INST_RUN : EV_NONE;
          default:     kind = EV_NONE;
        endcase
      end
    end

    if (IDX < 4) begin : g_grp_lo
      assign frozen = ctl.frz_all | ctl.frz_lo;
    end else begin : g_grp_hi
      assign frozen = ctl.frz_all | ctl.frz_hi;
    end
  endgenerate

  always_comb begin
    inc = '0;
    if (!frozen) begin
      case (kind)
        EV_INST:     inc = inst_done;
        EV_CYC:      inc = INST_W'(cyc_tick);
        EV_INST_RUN: inc = run_latch ? inst_done : '0;
        default:     inc = '0;
      endcase
    end
  end
endmodule

// File: rtl/pcb_counter.sv
module pcb_counter #(
  parameter int CNT_W = 32,
  parameter int INC_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_hit,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [INC_W-1:0] inc,
  input  logic             ovf_en,
  output logic [CNT_W-1:0] value,
  output logic             ovf_pulse
);
  localparam logic [CNT_W-1:0] SIGN_VAL = {1'b1, {(CNT_W-1){1'b0}}};

  logic [CNT_W:0]   sum;
  logic [CNT_W-1:0] nxt;
  logic             hit_thr;

  assign sum       = {1'b0, value} + (CNT_W+1)'(inc);
  assign hit_thr   = sum[CNT_W] | sum[CNT_W-1];
  assign ovf_pulse = (inc != '0) && ovf_en && hit_thr && !wr_hit;

  always_comb begin
    if (wr_hit)         nxt = wr_data;
    else if (ovf_pulse) nxt = SIGN_VAL;
    else                nxt = sum[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) value <= '0;
    else        value <= nxt;
  end

  // R10: software write wins over a same-cycle increment
  p_wr_prio_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> value == $past(wr_data));

  // R8: an overflow leaves the counter pinned at the sign value
  p_clamp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |=> value == SIGN_VAL);

  // R7: no increment and no write means the value holds
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (inc == '0 && !wr_hit) |=> $stable(value));
endmodule

// File: rtl/pcb_ctrl_regs.sv
module pcb_ctrl_regs
  import pcb_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [CNT_W-1:0]       wr_data,
  input  logic                   any_ovf,
  output ctl0_t                  ctl0,
  output logic [N_SEL*SEL_W-1:0] ctl1,
  output logic                   irq_flag
);
  localparam logic [ADDR_W-1:0] A_CTL0 = ADDR_W'(6);
  localparam logic [ADDR_W-1:0] A_CTL1 = ADDR_W'(7);
  localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(8);

  logic flag_clr;
  logic flag_set;

  assign flag_clr = wr_en && (wr_addr == A_FLAG) && wr_data[0];
  assign flag_set = any_ovf && ctl0.exc_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl0 <= '0;
      ctl1 <= '0;
    end else if (wr_en) begin
      if (wr_addr == A_CTL0) ctl0 <= ctl0_t'(wr_data[CTL0_W-1:0]);
      if (wr_addr == A_CTL1) ctl1 <= wr_data[N_SEL*SEL_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        irq_flag <= 1'b0;
    else if (flag_set) irq_flag <= 1'b1;
    else if (flag_clr) irq_flag <= 1'b0;
  end

  // R9: the flag stays up until software clears it
  p_irq_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && !flag_clr) |=> irq_flag);

  // R9: the flag only rises when exceptions were enabled
  p_irq_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_flag) |-> $past(ctl0.exc_en));
endmodule

// File: rtl/perf_counter_bank.sv
module perf_counter_bank
  import pcb_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 4,
  parameter int INST_W = 3,
  parameter int N_CNT  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [ADDR_W-1:0] reg_wr_addr,
  input  logic [CNT_W-1:0]  reg_wr_data,
  input  logic [ADDR_W-1:0] reg_rd_addr,
  output logic [CNT_W-1:0]  reg_rd_data,
  input  logic [INST_W-1:0] inst_done,
  input  logic              cyc_tick,
  input  logic              run_latch,
  output logic              irq
);
  localparam int SEL_BITS = N_SEL * SEL_W;

  ctl0_t                 ctl0;
  logic [SEL_BITS-1:0]   ctl1;
  logic                  irq_flag;
  logic [N_CNT-1:0]      wr_hit;
  logic [N_CNT-1:0]      frozen;
  logic [N_CNT-1:0]      ovf;
  logic [CNT_W-1:0]      cnt    [N_CNT];
  logic [INST_W-1:0]     inc    [N_CNT];

  pcb_ctrl_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (reg_wr_en),
    .wr_addr  (reg_wr_addr),
    .wr_data  (reg_wr_data),
    .any_ovf  (|ovf),
    .ctl0     (ctl0),
    .ctl1     (ctl1),
    .irq_flag (irq_flag)
  );

  for (genvar i = 0; i < N_CNT; i++) begin : g_cnt
    logic [SEL_W-1:0] sel_i;
    logic             ovf_en_i;

    if (i < N_SEL) begin : g_sel
      assign sel_i = ctl1[i*SEL_W +: SEL_W];
    end else begin : g_nosel
      assign sel_i = '0;
    end

    if (i == 0) begin : g_en1
      assign ovf_en_i = ctl0.ovf_en_c1;
    end else begin : g_enr
      assign ovf_en_i = ctl0.ovf_en_rest;
    end

    assign wr_hit[i] = reg_wr_en && (reg_wr_addr == ADDR_W'(i));

    pcb_event_decode #(.IDX(i), .INST_W(INST_W)) u_dec (
      .sel       (sel_i),
      .ctl       (ctl0),
      .inst_done (inst_done),
      .cyc_tick  (cyc_tick),
      .run_latch (run_latch),
      .frozen    (frozen[i]),
      .inc       (inc[i])
    );

    pcb_counter #(.CNT_W(CNT_W), .INC_W(INST_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_hit    (wr_hit[i]),
      .wr_data   (reg_wr_data),
      .inc       (inc[i]),
      .ovf_en    (ovf_en_i),
      .value     (cnt[i]),
      .ovf_pulse (ovf[i])
    );

    // R2: a frozen counter keeps its value unless software writes it
    p_frozen_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (frozen[i] && !wr_hit[i]) |=> $stable(cnt[i]));
  end

  // R6: run-latch event on counter 4 holds still while the latch is low
  p_run_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl1[3*SEL_W +: SEL_W] == SEL_C4_RUN && !run_latch && !wr_hit[3])
      |=> $stable(cnt[3]));

  assign irq = irq_flag;

  always_comb begin
    reg_rd_data = '0;
    if (reg_rd_addr < ADDR_W'(N_CNT)) begin
      for (int k = 0; k < N_CNT; k++)
        if (reg_rd_addr == ADDR_W'(k)) reg_rd_data = cnt[k];
    end else if (reg_rd_addr == ADDR_W'(N_CNT)) begin
      reg_rd_data[CTL0_W-1:0] = ctl0;
    end else if (reg_rd_addr == ADDR_W'(N_CNT+1)) begin
      reg_rd_data[SEL_BITS-1:0] = ctl1;
    end else if (reg_rd_addr == ADDR_W'(N_CNT+2)) begin
      reg_rd_data[0] = irq_flag;
    end
  end
endmodule

// File: tb/perf_counter_bank_tb.sv
`timescale 1ns/1ps
module perf_counter_bank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [3:0]  reg_wr_addr = '0;
  logic [31:0] reg_wr_data = '0;
  logic [3:0]  reg_rd_addr = '0;
  logic [31:0] reg_rd_data;
  logic [2:0]  inst_done = '0;
  logic        cyc_tick = 1'b0;
  logic        run_latch = 1'b0;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  perf_counter_bank u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr),
    .reg_wr_data(reg_wr_data), .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
    .inst_done(inst_done), .cyc_tick(cyc_tick), .run_latch(run_latch), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input string tag, input logic [3:0] a, input logic [31:0] exp);
    reg_rd_addr = a;
    #1;
    chk(tag, reg_rd_data, exp);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic run(input logic [2:0] n_inst, input logic tick, input logic rl, input int n);
    inst_done = n_inst; cyc_tick = tick; run_latch = rl;
    repeat (n) @(negedge clk);
    inst_done = '0; cyc_tick = 1'b0; run_latch = 1'b0;
  endtask

  task automatic clear_all();
    wr(4'd6, 32'h0);
    wr(4'd7, 32'h0);
    for (int i = 0; i < 6; i++) wr(4'(i), 32'h0);
    wr(4'd8, 32'h1);
  endtask

  task automatic t_reset();
    for (int i = 0; i < 9; i++) rd("R1 reset value", 4'(i), 32'h0);
    chk("R1 irq after reset", {31'b0, irq}, 32'h0);
    rd("R12 unmapped address", 4'd12, 32'h0);
  endtask

  task automatic t_fixed();
    clear_all();
    run(3'd3, 1'b1, 1'b0, 4);
    rd("R3 counter5 instructions", 4'd4, 32'd12);
    rd("R3 counter6 cycles", 4'd5, 32'd4);
  endtask

  task automatic t_generic_sel();
    clear_all();
    wr(4'd7, 32'h001E_0202);
    rd("R12 control word 1 readback", 4'd7, 32'h001E_0202);
    run(3'd5, 1'b1, 1'b0, 3);
    rd("R4 counter1 sel 02", 4'd0, 32'd15);
    rd("R4 counter2 sel 02", 4'd1, 32'd15);
    rd("R4 counter3 sel 1E", 4'd2, 32'd3);
  endtask

  task automatic t_c1_only();
    clear_all();
    wr(4'd7, 32'hFEF0_FEF0);
    run(3'd2, 1'b1, 1'b0, 4);
    rd("R5 counter1 sel F0 cycles", 4'd0, 32'd4);
    rd("R5 counter2 sel FE idle", 4'd1, 32'd0);
    rd("R5 counter3 sel F0 idle", 4'd2, 32'd0);
    rd("R5 counter4 sel FE idle", 4'd3, 32'd0);
    wr(4'd7, 32'h0000_00FE);
    wr(4'd0, 32'h0);
    run(3'd2, 1'b1, 1'b0, 4);
    rd("R5 counter1 sel FE instructions", 4'd0, 32'd8);
  endtask

  task automatic t_run_latch();
    clear_all();
    wr(4'd7, 32'hFAFA_FAFA);
    run(3'd3, 1'b1, 1'b1, 2);
    run(3'd3, 1'b1, 1'b0, 3);
    rd("R6 counter4 counts with latch", 4'd3, 32'd6);
    rd("R6 counter3 sel FA idle", 4'd2, 32'd0);
    rd("R6 counter1 sel FA idle", 4'd0, 32'd0);
  endtask

  task automatic t_unknown();
    clear_all();
    wr(4'd7, 32'h5503_7F55);
    run(3'd6, 1'b1, 1'b1, 3);
    for (int i = 0; i < 4; i++) rd("R7 unknown selector idle", 4'(i), 32'd0);
    rd("R7 counter5 still counts", 4'd4, 32'd18);
  endtask

  task automatic t_freeze();
    clear_all();
    wr(4'd7, 32'h0000_0002);
    wr(4'd6, 32'h2);
    run(3'd1, 1'b1, 1'b0, 3);
    rd("R2 freeze lo stops c1", 4'd0, 32'd0);
    rd("R2 freeze lo spares c5", 4'd4, 32'd3);
    rd("R2 freeze lo spares c6", 4'd5, 32'd3);
    wr(4'd6, 32'h4);
    run(3'd1, 1'b1, 1'b0, 3);
    rd("R2 freeze hi spares c1", 4'd0, 32'd3);
    rd("R2 freeze hi stops c5", 4'd4, 32'd3);
    rd("R2 freeze hi stops c6", 4'd5, 32'd3);
    wr(4'd6, 32'h1);
    run(3'd1, 1'b1, 1'b0, 3);
    rd("R2 freeze all c1", 4'd0, 32'd3);
    rd("R2 freeze all c5", 4'd4, 32'd3);
  endtask

  task automatic t_ctl_timing();
    clear_all();
    inst_done = 3'd1;
    wr(4'd6, 32'h1);
    rd("R11 old control applies in write cycle", 4'd4, 32'd1);
    @(negedge clk);
    inst_done = '0;
    rd("R11 new control applies next cycle", 4'd4, 32'd1);
  endtask

  task automatic t_wr_prio();
    clear_all();
    inst_done = 3'd4;
    wr(4'd4, 32'd100);
    rd("R10 write wins over increment", 4'd4, 32'd100);
    @(negedge clk);
    inst_done = '0;
    rd("R10 counting resumes", 4'd4, 32'd104);
  endtask

  task automatic t_overflow();
    clear_all();
    wr(4'd6, 32'h10);
    wr(4'd4, 32'h7FFF_FFFD);
    run(3'd7, 1'b0, 1'b0, 1);
    rd("R8 clamp to sign value", 4'd4, 32'h8000_0000);
    chk("R9 no irq without exception enable", {31'b0, irq}, 32'h0);
    wr(4'd6, 32'h0);
    wr(4'd4, 32'hFFFF_FFFE);
    run(3'd5, 1'b0, 1'b0, 1);
    rd("R8 wrap without enable", 4'd4, 32'd3);
    wr(4'd7, 32'h0000_0002);
    wr(4'd6, 32'h10);
    wr(4'd0, 32'h7FFF_FFFF);
    run(3'd2, 1'b0, 1'b0, 1);
    rd("R8 counter1 ignores shared enable", 4'd0, 32'h8000_0001);
    wr(4'd6, 32'h08);
    wr(4'd0, 32'h7FFF_FFFF);
    run(3'd2, 1'b0, 1'b0, 1);
    rd("R8 counter1 own enable clamps", 4'd0, 32'h8000_0000);
  endtask

  task automatic t_irq();
    clear_all();
    wr(4'd6, 32'h30);
    wr(4'd4, 32'h7FFF_FFFF);
    chk("R9 irq low before overflow", {31'b0, irq}, 32'h0);
    run(3'd1, 1'b0, 1'b0, 1);
    chk("R9 irq set on overflow edge", {31'b0, irq}, 32'h1);
    repeat (3) @(negedge clk);
    chk("R9 irq sticky", {31'b0, irq}, 32'h1);
    rd("R12 flag readback", 4'd8, 32'h1);
    wr(4'd8, 32'h0);
    chk("R9 write bit0 zero keeps flag", {31'b0, irq}, 32'h1);
    wr(4'd8, 32'h1);
    chk("R9 clear by write", {31'b0, irq}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fixed();
    t_generic_sel();
    t_c1_only();
    t_run_latch();
    t_unknown();
    t_freeze();
    t_ctl_timing();
    t_wr_prio();
    t_overflow();
    t_irq();
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule